// File: doc/BRIEF.md
# Rate Sensor Self-Test Sequencer

This block runs the built-in self-test of a serial angular-rate sensor through a host serial controller that it does not contain. On a start strobe it sends the controller a configuration write that turns on positive or negative electromechanical excitation with the rate channel selected. It then requests one sample, writes a configuration with excitation off, and requests a second sample. It subtracts the baseline sample from the excited sample and reports whether the signed difference falls inside a window that software programs.

Samples are 14-bit offset-binary codes, where zero rate reads 8192. A healthy sensor moves by about +6226 codes under positive excitation and by about -6226 under negative excitation. For a negative test the difference is negated before the window compare, so one window serves both polarities. Commands use a valid/ready handshake. A read is complete when the controller returns a response strobe with the sample.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `pass`, `delta` and `cmd_valid` are all 0 until a sequence runs.
- R2: A `start` pulse while idle begins a sequence. Its first command is a configuration write (`cmd_write`=1) of byte 0x22 when `neg_test`=0 and 0x21 when `neg_test`=1.
- R3: The commands are issued in a fixed order: test write, read (`cmd_write`=0), write of 0x20 (excitation off, rate channel), read. There are exactly four commands per sequence.
- R4: A command stays valid, with the same `cmd_write` and `cmd_byte`, until a cycle in which `ctl_ready` is 1 accepts it.
- R5: A response is taken only after the read command has been accepted. A `rsp_valid` in the same cycle as that acceptance is ignored.
- R6: `delta` is the signed 15-bit value of the excited sample minus the baseline sample, both taken as unsigned 14-bit codes.
- R7: For a positive test, `pass` is 1 exactly when `win_lo` <= `delta` <= `win_hi`, with both bounds inclusive.
- R8: For a negative test, the negated `delta` is compared against the same inclusive window.
- R9: `done` is high for exactly one cycle per sequence. `pass` and `delta` are valid from that cycle and stay held until the next evaluation.
- R10: A `start` pulse while a sequence is running is ignored. This includes a pulse with the other polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a self-test sequence (one-cycle strobe) |
| neg_test | input | 1 | Polarity select, sampled with start: 1 = negative excitation |
| win_lo | input | 15 | Signed lower bound of the pass window (inclusive) |
| win_hi | input | 15 | Signed upper bound of the pass window (inclusive) |
| cmd_valid | output | 1 | Command request to the serial controller |
| cmd_write | output | 1 | 1 = configuration write, 0 = sample read |
| cmd_byte | output | 8 | Configuration byte for a write, 0 for a read |
| ctl_ready | input | 1 | Controller accepts the command this cycle |
| rsp_valid | input | 1 | Controller returns a sample this cycle |
| rsp_data | input | 14 | Offset-binary sample |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Self-test verdict |
| delta | output | 15 | Signed excited-minus-baseline difference |

## Verification
Two things can happen in the same clock edge: the controller accepting a read command and a response strobe arriving. The bench's controller model injects a response with junk data in exactly the cycle it accepts each read. The correct sample follows a few cycles later. The reported `delta` must match the correct samples, which shows the junk was never captured. In a separate test a second `start` of opposite polarity arrives while a sequence is running. The judgement there rests on the command log and the verdict still following the first polarity.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_TEST = 3'd1,
    ST_RD_TEST = 3'd2,
    ST_WR_OFF  = 3'd3,
    ST_RD_OFF  = 3'd4,
    ST_EVAL    = 3'd5,
    ST_DONE    = 3'd6
  } seq_state_e;

  localparam logic [7:0] CFG_RATE_OFF = 8'h20;
  localparam logic [7:0] CFG_RATE_POS = 8'h22;
  localparam logic [7:0] CFG_RATE_NEG = 8'h21;
endpackage

// File: rtl/st_rst_sync.sv
module st_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/st_fsm.sv
module st_fsm
  import selftest_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       neg_test,
  input  logic       ctl_ready,
  input  logic       rsp_valid,
  output logic       cmd_valid,
  output logic       cmd_write,
  output logic [7:0] cmd_byte,
  output logic       ld_test,
  output logic       ld_base,
  output logic       eval_en,
  output logic       done,
  output logic       neg_q
);
  seq_state_e state_q, state_d;
  logic       issued_q, issued_d;
  logic       neg_d;
  logic       in_rd, in_wr, accept, got_rsp;

  assign in_rd   = (state_q == ST_RD_TEST) || (state_q == ST_RD_OFF);
  assign in_wr   = (state_q == ST_WR_TEST) || (state_q == ST_WR_OFF);
  assign accept  = cmd_valid && ctl_ready;
  assign got_rsp = in_rd && issued_q && rsp_valid;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start)     state_d = ST_WR_TEST;
      ST_WR_TEST: if (ctl_ready) state_d = ST_RD_TEST;
      ST_RD_TEST: if (got_rsp)   state_d = ST_WR_OFF;
      ST_WR_OFF:  if (ctl_ready) state_d = ST_RD_OFF;
      ST_RD_OFF:  if (got_rsp)   state_d = ST_EVAL;
      ST_EVAL:                   state_d = ST_DONE;
      ST_DONE:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    issued_d = issued_q;
    if (in_rd && accept) issued_d = 1'b1;
    else if (got_rsp)    issued_d = 1'b0;
  end

  assign neg_d = (state_q == ST_IDLE && start) ? neg_test : neg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
      neg_q    <= neg_d;
    end
  end

  always_comb begin
    cmd_valid = in_wr || (in_rd && !issued_q);
    cmd_write = in_wr;
    cmd_byte  = 8'h00;
    if (state_q == ST_WR_TEST)     cmd_byte = neg_q ? CFG_RATE_NEG : CFG_RATE_POS;
    else if (state_q == ST_WR_OFF) cmd_byte = CFG_RATE_OFF;
  end

  assign ld_test = got_rsp && (state_q == ST_RD_TEST);
  assign ld_base = got_rsp && (state_q == ST_RD_OFF);
  assign eval_en = (state_q == ST_EVAL);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/st_judge.sv
module st_judge #(
  parameter int SMP_W = 14,
  localparam int DW   = SMP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SMP_W-1:0]     rsp_data,
  input  logic                 ld_test,
  input  logic                 ld_base,
  input  logic                 eval_en,
  input  logic                 neg,
  input  logic signed [DW-1:0] win_lo,
  input  logic signed [DW-1:0] win_hi,
  output logic signed [DW-1:0] delta,
  output logic                 pass
);
  logic [SMP_W-1:0]     test_q, base_q;
  logic signed [DW-1:0] diff, norm;
  logic                 in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
      base_q <= '0;
    end else begin
      if (ld_test) test_q <= rsp_data;
      if (ld_base) base_q <= rsp_data;
    end
  end

  assign diff   = $signed({1'b0, test_q}) - $signed({1'b0, base_q});
  assign norm   = neg ? -diff : diff;
  assign in_win = (norm >= win_lo) && (norm <= win_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta <= '0;
      pass  <= 1'b0;
    end else if (eval_en) begin
      delta <= diff;
      pass  <= in_win;
    end
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
  parameter int SMP_W = 14,
  localparam int DW   = SMP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 neg_test,
  input  logic signed [DW-1:0] win_lo,
  input  logic signed [DW-1:0] win_hi,
  output logic                 cmd_valid,
  output logic                 cmd_write,
  output logic [7:0]           cmd_byte,
  input  logic                 ctl_ready,
  input  logic                 rsp_valid,
  input  logic [SMP_W-1:0]     rsp_data,
  output logic                 done,
  output logic                 pass,
  output logic signed [DW-1:0] delta
);
  logic rst_n_s, ld_test, ld_base, eval_en, neg_q;

  st_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  st_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_s), .start(start), .neg_test(neg_test),
    .ctl_ready(ctl_ready), .rsp_valid(rsp_valid),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_byte(cmd_byte),
    .ld_test(ld_test), .ld_base(ld_base), .eval_en(eval_en),
    .done(done), .neg_q(neg_q)
  );

  st_judge #(.SMP_W(SMP_W)) u_judge (
    .clk(clk), .rst_n(rst_n_s), .rsp_data(rsp_data),
    .ld_test(ld_test), .ld_base(ld_base), .eval_en(eval_en), .neg(neg_q),
    .win_lo(win_lo), .win_hi(win_hi), .delta(delta), .pass(pass)
  );
endmodule

// File: rtl/selftest_seq_chk.sv
module selftest_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_write,
  input logic [7:0] cmd_byte,
  input logic       ctl_ready,
  input logic       done
);
  assert_hold_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !ctl_ready |=> cmd_valid);
  assert_hold_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !ctl_ready |=> $stable(cmd_byte) && $stable(cmd_write));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_quiet_at_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);
  assert_legal_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_write |-> (cmd_byte == 8'h20 || cmd_byte == 8'h21 || cmd_byte == 8'h22));
  assert_read_byte_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_write |-> cmd_byte == 8'h00);
endmodule

bind selftest_seq selftest_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_byte(cmd_byte), .ctl_ready(ctl_ready), .done(done)
);

// File: tb/tb_selftest_seq.sv
module tb_selftest_seq;
  logic clk = 1'b0;
  logic rst_n;
  logic start, neg_test, ctl_ready, rsp_valid;
  logic signed [14:0] win_lo, win_hi, delta;
  logic [13:0] rsp_data;
  logic cmd_valid, cmd_write, done, pass;
  logic [7:0] cmd_byte;

  int n_chk = 0, n_fail = 0;
  int val_test, val_base, rd_idx, rd_pend, stall_left, stall_every;
  bit inject_junk;
  int log_n;
  logic [7:0] log_byte [8];
  logic       log_wr [8];

  always #4 clk = ~clk;

  selftest_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .neg_test(neg_test),
    .win_lo(win_lo), .win_hi(win_hi), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_byte(cmd_byte), .ctl_ready(ctl_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done),
    .pass(pass), .delta(delta)
  );

  // controller model: all decisions at the falling edge
  always @(negedge clk) begin
    rsp_valid <= 1'b0;
    rsp_data  <= 14'h3fff;
    if (rd_pend > 0) begin
      rd_pend = rd_pend - 1;
      if (rd_pend == 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= (rd_idx == 0) ? val_test[13:0] : val_base[13:0];
        rd_idx = rd_idx + 1;
      end
    end
    if (stall_left > 0) begin
      ctl_ready = 1'b0;
      stall_left = stall_left - 1;
    end else ctl_ready = 1'b1;
    if (rst_n && cmd_valid && ctl_ready) begin
      if (log_n < 8) begin
        log_byte[log_n] = cmd_byte;
        log_wr[log_n]   = cmd_write;
      end
      log_n = log_n + 1;
      stall_left = stall_every;
      if (!cmd_write) begin
        rd_pend = 4;
        if (inject_junk) begin
          rsp_valid <= 1'b1;
          rsp_data  <= 14'h1234;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // runs one sequence; returns after done plus a few cycles
  task automatic run(input bit neg, input int t, input int b, input int lo, input int hi,
                     input bit restart_mid, output int dones, output bit got_pass,
                     output int got_delta);
    int wait_n;
    val_test = t; val_base = b; rd_idx = 0; log_n = 0;
    win_lo = 15'(lo); win_hi = 15'(hi);
    @(negedge clk); neg_test = neg; start = 1'b1;
    @(negedge clk); start = 1'b0;
    dones = 0; wait_n = 0; got_pass = 0; got_delta = 0;
    while (dones == 0 && wait_n < 400) begin
      if (restart_mid && wait_n == 3) begin
        start = 1'b1; neg_test = ~neg;
      end else start = 1'b0;
      @(negedge clk);
      wait_n++;
      if (done) begin
        dones++; got_pass = pass; got_delta = int'(delta);
      end
    end
    start = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (done) dones++;
    end
    check(pass == got_pass && int'(delta) == got_delta, "R9 held", int'(delta), got_delta);
  endtask

  task automatic check_log(input bit neg);
    check(log_n == 4, "R3 count", log_n, 4);
    check(log_wr[0] && log_byte[0] == (neg ? 8'h21 : 8'h22), "R2 first", log_byte[0], neg ? 33 : 34);
    check(!log_wr[1] && log_wr[2] && !log_wr[3] && log_byte[2] == 8'h20, "R3 order",
          log_byte[2], 32);
  endtask

  task automatic t_positive_nominal();
    int d; bit p; int dl;
    run(0, 14418, 8192, 5000, 7500, 0, d, p, dl);
    check(d == 1, "R9 one done", d, 1);
    check(dl == 6226, "R6 delta pos", dl, 6226);
    check(p == 1, "R7 pass", p, 1);
    check_log(0);
  endtask

  task automatic t_negative_nominal();
    int d; bit p; int dl;
    run(1, 1966, 8192, 5000, 7500, 0, d, p, dl);
    check(dl == -6226, "R6 delta neg", dl, -6226);
    check(p == 1, "R8 neg pass", p, 1);
    check_log(1);
  endtask

  task automatic t_window_edges();
    int d; bit p; int dl;
    run(0, 8192 + 6226, 8192, 5000, 6226, 0, d, p, dl);
    check(p == 1, "R7 hi inclusive", p, 1);
    run(0, 8192 + 6227, 8192, 5000, 6226, 0, d, p, dl);
    check(p == 0, "R7 above hi", p, 0);
    run(0, 8192 + 5000, 8192, 5000, 6226, 0, d, p, dl);
    check(p == 1, "R7 lo inclusive", p, 1);
    run(0, 8192 + 4999, 8192, 5000, 6226, 0, d, p, dl);
    check(p == 0, "R7 below lo", p, 0);
  endtask

  task automatic t_negative_wrong_sign();
    int d; bit p; int dl;
    run(1, 14418, 8192, 5000, 7500, 0, d, p, dl);
    check(dl == 6226 && p == 0, "R8 wrong sign fails", p, 0);
  endtask

  task automatic t_extremes();
    int d; bit p; int dl;
    run(1, 0, 16383, 16000, 16383, 0, d, p, dl);
    check(dl == -16383, "R6 extreme delta", dl, -16383);
    check(p == 1, "R8 extreme pass", p, 1);
  endtask

  task automatic t_stall_and_junk();
    int d; bit p; int dl;
    stall_every = 3; inject_junk = 1;
    run(0, 9000, 8100, 800, 1000, 0, d, p, dl);
    check(dl == 900, "R5 junk ignored", dl, 900);
    check(p == 1, "R4 stalled pass", p, 1);
    check_log(0);
    stall_every = 0; inject_junk = 0;
  endtask

  task automatic t_restart_ignored();
    int d; bit p; int dl;
    stall_every = 2;
    run(0, 14418, 8192, 5000, 7500, 1, d, p, dl);
    check(d == 1 && log_n == 4, "R10 single run", log_n, 4);
    check(log_byte[0] == 8'h22 && p == 1, "R10 polarity kept", log_byte[0], 34);
    stall_every = 0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; neg_test = 1'b0; win_lo = '0; win_hi = '0;
    ctl_ready = 1'b1; rsp_valid = 1'b0; rsp_data = '0;
    val_test = 0; val_base = 0; rd_idx = 0; rd_pend = 0; stall_left = 0;
    stall_every = 0; inject_junk = 0; log_n = 0;
    repeat (3) @(negedge clk);
    check(!done && !pass && delta == 0 && !cmd_valid, "R1 in reset", int'(delta), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!done && !pass && delta == 0 && !cmd_valid, "R1 after reset", int'(cmd_valid), 0);
    t_positive_nominal();
    t_negative_nominal();
    t_window_edges();
    t_negative_wrong_sign();
    t_extremes();
    t_stall_and_junk();
    t_restart_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule